// File: doc/BRIEF.md
# Sixteen-bit Wrap-and-Interrupt Timer Channel

One channel of a general-purpose 16-bit timer. It has three bus-visible registers: a running count, a compare value and a control/status word. The count advances by one on each enabled tick. The tick is either every system clock or a channel-specific slower source. When the count is at the compare value, or at 0xFFFF, and a tick arrives, an event fires. The count then wraps to zero, or keeps going if wrap-on-compare is off. The event can also raise an interrupt pulse. Sticky status bits record events until software reads the control word.

The channel number is a parameter that picks the slow tick source: a dot-rate divider, an external line tick, or a divide-by-eight prescaler with a halt bit. Bus accesses are single-cycle. Reads are combinational from the registers. A write takes effect at the next clock edge. Register select: 0 = count, 1 = control, 2 = compare, 3 = reads zero.

Control word bits: 0 halt (channel 2), 3 wrap-on-compare, 4 interrupt on compare, 5 interrupt on overflow, 6 repeat interrupts, 8 source A, 9 source B, 10 any-event (sticky), 11 compare-hit (sticky), 12 overflow-hit (sticky), 13..15 zero.

Top module: `tmr_channel`

## Requirements
- R1: While reset is asserted, count, control word and compare value all read 0 and irq_o is low.
- R2: With bit 3 set, a tick while the count equals the compare value T returns the count to 0. The event period is T+1 ticks.
- R3: A tick at count 0xFFFF returns the count to 0 and sets sticky bit 12.
- R4: irq_o is a registered one-cycle pulse. It is raised by a compare event when bit 4 is set, or by an overflow event when bit 5 is set. It rises at the same edge that applies the event. Events whose enable is clear raise nothing.
- R5: With bit 6 set, every qualifying event pulses irq_o. With bit 6 clear, only the first qualifying event after a control write pulses.
- R6: A compare event sets bit 11, and any event sets bit 10. A read of the control word returns the current value, then clears bits 11 and 12 at that edge; bit 10 stays.
- R7: A control write stores bits 0..9 and clears bits 10..15. It also zeroes the count, re-arms one-shot interrupts and restarts the prescaler.
- R8: Tick source: channel 0 with bit 8 ticks once per 5 clocks; channel 1 with bit 8 ticks on each alt_tick_i pulse; channel 2 with bit 9 ticks once per 8 clocks; otherwise every clock. After a control write, the first prescaled tick comes DIV clocks later.
- R9: On channel 2, bit 0 halts the count. On other channels, bit 0 has no effect.
- R10: A count write loads the low 16 bits of the bus data. A compare write leaves the count running undisturbed. A bus write in the same cycle overrides a tick and suppresses its event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alt_tick_i | input | 1 | Single-cycle external line tick |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | BUS_W | Write data, low 16 bits used |
| bus_rdata_o | output | 16 | Read data of selected register |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The bench builds three instances side by side, with CHAN set to 2, 0 and 1, the default dividers of 5 and 8, and a shared bus. Every source branch is therefore exercised by the same control writes, including bits that one channel honours and another ignores. The channel-2 instance carries the interrupt scoreboard. A compare value of 9 brings repeated compare wraps within tens of cycles. A count preset of 0xFFF0, written through a wide bus word, brings the overflow wrap and the truncation within reach.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int MODE_W = 16;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {
    SEL_COUNT   = 2'd0,
    SEL_CTRL    = 2'd1,
    SEL_COMPARE = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  localparam int CB_HALT    = 0;
  localparam int CB_WRAP    = 3;
  localparam int CB_IE_CMP  = 4;
  localparam int CB_IE_OVF  = 5;
  localparam int CB_REPEAT  = 6;
  localparam int CB_SRC_A   = 8;
  localparam int CB_SRC_B   = 9;
  localparam int CB_ANY     = 10;
  localparam int CB_HIT_CMP = 11;
  localparam int CB_HIT_OVF = 12;
  localparam int CB_WR_TOP  = 9;

  typedef struct packed {
    logic [CNT_W-1:0] nxt;
    logic             at_cmp;
    logic             at_max;
  } step_t;

  function automatic step_t count_step(logic [CNT_W-1:0] cur,
                                       logic [CNT_W-1:0] cmp,
                                       logic wrap_on_cmp);
    step_t s;
    s.at_cmp = (cur == cmp);
    s.at_max = (cur == CNT_MAX);
    if (s.at_max || (s.at_cmp && wrap_on_cmp)) s.nxt = '0;
    else                                       s.nxt = cur + 1'b1;
    return s;
  endfunction

  function automatic logic irq_gate(logic ev_cmp, logic ev_ovf,
                                    logic en_cmp, logic en_ovf,
                                    logic rep, logic fired);
    return ((ev_cmp && en_cmp) || (ev_ovf && en_ovf)) && (rep || !fired);
  endfunction

  function automatic logic [MODE_W-1:0] ctrl_from_write(logic [CNT_W-1:0] w);
    logic [MODE_W-1:0] r;
    r = '0;
    r[CB_WR_TOP:0] = w[CB_WR_TOP:0];
    return r;
  endfunction

  function automatic logic [MODE_W-1:0] ctrl_after_events(logic [MODE_W-1:0] m,
                                                          logic rd_clr,
                                                          logic ev_cmp,
                                                          logic ev_ovf);
    logic [MODE_W-1:0] r;
    r = m;
    if (rd_clr) begin
      r[CB_HIT_CMP] = 1'b0;
      r[CB_HIT_OVF] = 1'b0;
    end
    r[CB_HIT_CMP] = r[CB_HIT_CMP] | ev_cmp;
    r[CB_HIT_OVF] = r[CB_HIT_OVF] | ev_ovf;
    r[CB_ANY]     = r[CB_ANY] | ev_cmp | ev_ovf;
    return r;
  endfunction
endpackage

// File: rtl/tmr_divider.sv
`timescale 1ns/1ps
module tmr_divider #(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic pulse_o
);
  localparam int DW = (DIV < 2) ? 1 : $clog2(DIV);
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ph_q <= '0;
    else if (restart_i)       ph_q <= '0;
    else if (ph_q == LAST)    ph_q <= '0;
    else                      ph_q <= ph_q + 1'b1;
  end

  assign pulse_o = (ph_q == LAST);

  AST_DIV_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= LAST); // R8
endmodule

// File: rtl/tmr_tick_sel.sv
`timescale 1ns/1ps
module tmr_tick_sel #(
  parameter int CHAN     = 2,
  parameter int DOT_DIV  = 5,
  parameter int FAST_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic sel_a_i,
  input  logic sel_b_i,
  input  logic halt_i,
  input  logic alt_tick_i,
  output logic tick_o
);
  generate
    if (CHAN == 0) begin : g_dot
      logic dot_pulse;
      tmr_divider #(.DIV(DOT_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .pulse_o(dot_pulse));
      assign tick_o = sel_a_i ? dot_pulse : 1'b1;
    end else if (CHAN == 1) begin : g_line
      assign tick_o = sel_a_i ? alt_tick_i : 1'b1;
    end else begin : g_fast
      logic fast_pulse;
      tmr_divider #(.DIV(FAST_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .pulse_o(fast_pulse));
      assign tick_o = halt_i ? 1'b0 : (sel_b_i ? fast_pulse : 1'b1);
    end
  endgenerate
endmodule

// File: rtl/tmr_count_unit.sv
`timescale 1ns/1ps
module tmr_count_unit
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             cnt_wr_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             wrap_on_cmp_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] compare_o,
  output logic             ev_cmp_o,
  output logic             ev_ovf_o
);
  logic [CNT_W-1:0] cnt_q, cmp_q;
  step_t            step;
  logic             hold;

  assign step     = count_step(cnt_q, cmp_q, wrap_on_cmp_i);
  assign hold     = restart_i | cnt_wr_i;
  assign ev_cmp_o = tick_i & ~hold & step.at_cmp;
  assign ev_ovf_o = tick_i & ~hold & step.at_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (cnt_wr_i)  cnt_q <= wdata_i;
    else if (tick_i)    cnt_q <= step.nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmp_q <= '0;
    else if (cmp_wr_i) cmp_q <= wdata_i;
  end

  assign count_o   = cnt_q;
  assign compare_o = cmp_q;

  AST_OVF_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf_o |=> (cnt_q == '0)); // R3
  AST_CMP_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmp_o && wrap_on_cmp_i) |=> (cnt_q == '0)); // R2
  AST_CMP_WR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr_i && !hold && !tick_i) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/tmr_irq_unit.sv
`timescale 1ns/1ps
module tmr_irq_unit
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rearm_i,
  input  logic ev_cmp_i,
  input  logic ev_ovf_i,
  input  logic en_cmp_i,
  input  logic en_ovf_i,
  input  logic repeat_i,
  output logic irq_o
);
  logic fire, fired_q, irq_q;

  assign fire = irq_gate(ev_cmp_i, ev_ovf_i, en_cmp_i, en_ovf_i, repeat_i, fired_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      irq_q <= fire;
      if (rearm_i)   fired_q <= 1'b0;
      else if (fire) fired_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(ev_cmp_i || ev_ovf_i)); // R4
  AST_ONE_SHOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!repeat_i && fired_q && !rearm_i) |=> !irq_q); // R5
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CHAN     = 2,
  parameter int DOT_DIV  = 5,
  parameter int FAST_DIV = 8,
  parameter int BUS_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alt_tick_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o,
  output logic             irq_o
);
  logic [MODE_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  wdata16, count, compare;
  logic              wr_cnt, wr_ctrl, wr_cmp, rd_ctrl;
  logic              tick, ev_cmp, ev_ovf;

  assign wdata16 = bus_wdata_i[CNT_W-1:0];
  assign wr_cnt  = bus_wr_i && (bus_addr_i == SEL_COUNT);
  assign wr_ctrl = bus_wr_i && (bus_addr_i == SEL_CTRL);
  assign wr_cmp  = bus_wr_i && (bus_addr_i == SEL_COMPARE);
  assign rd_ctrl = bus_rd_i && (bus_addr_i == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_from_write(wdata16);
    else              ctrl_q <= ctrl_after_events(ctrl_q, rd_ctrl, ev_cmp, ev_ovf);
  end

  tmr_tick_sel #(.CHAN(CHAN), .DOT_DIV(DOT_DIV), .FAST_DIV(FAST_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart_i(wr_ctrl),
    .sel_a_i(ctrl_q[CB_SRC_A]), .sel_b_i(ctrl_q[CB_SRC_B]),
    .halt_i(ctrl_q[CB_HALT]), .alt_tick_i(alt_tick_i), .tick_o(tick));

  tmr_count_unit u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .restart_i(wr_ctrl),
    .cnt_wr_i(wr_cnt), .cmp_wr_i(wr_cmp), .wdata_i(wdata16),
    .wrap_on_cmp_i(ctrl_q[CB_WRAP]), .count_o(count), .compare_o(compare),
    .ev_cmp_o(ev_cmp), .ev_ovf_o(ev_ovf));

  tmr_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .rearm_i(wr_ctrl),
    .ev_cmp_i(ev_cmp), .ev_ovf_i(ev_ovf),
    .en_cmp_i(ctrl_q[CB_IE_CMP]), .en_ovf_i(ctrl_q[CB_IE_OVF]),
    .repeat_i(ctrl_q[CB_REPEAT]), .irq_o(irq_o));

  always_comb begin
    case (bus_addr_i)
      SEL_COUNT:   bus_rdata_o = count;
      SEL_CTRL:    bus_rdata_o = ctrl_q;
      SEL_COMPARE: bus_rdata_o = compare;
      default:     bus_rdata_o = '0;
    endcase
  end

  AST_RD_CLEARS_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !wr_ctrl && !ev_cmp && !ev_ovf)
      |=> (ctrl_q[CB_HIT_OVF] == 1'b0 && ctrl_q[CB_HIT_CMP] == 1'b0)); // R6

  generate
    if (CHAN == 2) begin : g_halt_chk
      AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_HALT] && !wr_cnt && !wr_ctrl) |=> $stable(count)); // R9
    end
  endgenerate
endmodule

// File: tb/tmr_channel_tb_top.sv
`timescale 1ns/1ps
module tmr_channel_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, alt = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [15:0] rdata2, rdata0, rdata1;
  logic        irq2, irq0, irq1;
  int unsigned cyc = 0;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;
  int unsigned exp_at[$];
  string       exp_tag[$];
  logic [15:0] v2, v0, v1;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr_channel #(.CHAN(2)) dut_i (.clk(clk), .rst_n(rst_n), .alt_tick_i(alt),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata2), .irq_o(irq2));
  tmr_channel #(.CHAN(0)) dut_c0 (.clk(clk), .rst_n(rst_n), .alt_tick_i(alt),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata0), .irq_o(irq0));
  tmr_channel #(.CHAN(1)) dut_c1 (.clk(clk), .rst_n(rst_n), .alt_tick_i(alt),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata1), .irq_o(irq1));

  task automatic check(input string tag, input int act, input int expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d,
                           output int unsigned edge_c);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    edge_c = cyc + 1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output int unsigned c);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1;
    c = cyc; v2 = rdata2; v0 = rdata0; v1 = rdata1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_until(input int unsigned c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic expect_irq(input int unsigned at, input string tag);
    exp_at.push_back(at);
    exp_tag.push_back(tag);
  endtask

  task automatic drained(input string tag);
    check(tag, exp_at.size(), 0);
    exp_at.delete();
    exp_tag.delete();
  endtask

  // monitor: every pulse on the channel-2 interrupt must match the scoreboard head
  always @(negedge clk) begin
    if (rst_n && irq2) begin
      if (exp_at.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R4: actual pulse at cycle %0d expected none", cyc);
      end else begin
        check(exp_tag.pop_front(), cyc, exp_at.pop_front());
      end
    end
  end

  initial begin
    int unsigned w, w2, c, tmp;
    repeat (3) @(negedge clk);
    bus_read(2'd1, c); check("R1 ctrl in reset", v2, 16'h0000);
    bus_read(2'd2, c); check("R1 compare in reset", v2, 16'h0000);
    bus_read(2'd0, c); check("R1 count in reset", v2, 16'h0000);
    check("R1 irq in reset", irq2, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 + R5 repeat: compare 9, wrap, compare irq, repeat
    bus_write(2'd2, 32'd9, tmp);
    bus_write(2'd1, 32'h0058, w);
    expect_irq(w + 10, "R2 R4 first wrap");
    expect_irq(w + 20, "R2 R5 second wrap");
    expect_irq(w + 30, "R2 R5 third wrap");
    wait_until(w + 32);
    bus_read(2'd1, c); check("R6 ctrl before clear", v2, 16'h0C58);
    bus_read(2'd1, c); check("R6 ctrl after clear", v2, 16'h0458);
    bus_write(2'd1, 32'h0000, tmp);
    drained("R2 all pulses seen");

    // R5 one-shot, re-armed by the control write
    bus_write(2'd1, 32'h0018, w);
    expect_irq(w + 10, "R5 one-shot pulse");
    wait_until(w + 45);
    drained("R5 one-shot only once");

    // R3 overflow with truncated count write (R10)
    bus_write(2'd1, 32'h0020, w);
    bus_write(2'd0, 32'h0012FFF0, w2);
    expect_irq(w2 + 16, "R3 R10 overflow pulse");
    wait_until(w2 + 18);
    bus_read(2'd1, c); check("R3 overflow sticky", v2, 16'h1420);
    drained("R3 overflow seen");

    // R10 compare write keeps count; count write takes low half
    bus_write(2'd1, 32'h0000, w);
    wait_until(w + 5);
    bus_read(2'd0, c); check("R7 count restarted", v2, c - w);
    bus_write(2'd2, 32'h0100, tmp);
    bus_read(2'd0, c); check("R10 count kept over compare write", v2, c - w);
    bus_read(2'd2, c); check("R10 compare readback", v2, 16'h0100);
    bus_write(2'd0, 32'hABCD0007, w);
    bus_read(2'd0, c); check("R10 count low half", v2, 7 + c - w);

    // R8 source A on all channels
    bus_write(2'd1, 32'h0100, w);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); alt = 1'b1;
      @(negedge clk); alt = 1'b0;
      @(negedge clk);
    end
    wait_until(w + 40);
    bus_read(2'd0, c);
    check("R8 ch0 dot divide", v0, (c - w) / 5);
    check("R8 ch1 line ticks", v1, 7);
    check("R8 ch2 ignores bit 8", v2, c - w);

    // R8 source B
    bus_write(2'd1, 32'h0200, w);
    wait_until(w + 43);
    bus_read(2'd0, c);
    check("R8 ch2 divide by 8", v2, (c - w) / 8);
    check("R8 ch0 ignores bit 9", v0, c - w);

    // R9 halt
    bus_write(2'd1, 32'h0201, w);
    wait_until(w + 20);
    bus_read(2'd0, c);
    check("R9 ch2 halted", v2, 0);
    check("R9 ch0 ignores bit 0", v0, c - w);

    // R7 status and top bits not writable
    bus_write(2'd1, 32'h0000FFFF, w);
    wait_until(w + 4);
    bus_read(2'd1, c); check("R7 ctrl write mask", v2, 16'h03FF);
    bus_read(2'd0, c); check("R7 R9 count zero and halted", v2, 0);
    drained("R4 no stray pulses");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule